// File: doc/BRIEF.md
# Write-Back Cache Tag Controller

This block keeps the tag state of a set-associative cache that uses write-back and write-allocate. A requester presents one read or store at a time, with an address and a byte count. The block reports hit or miss one cycle after it accepts the request. For every way of every set it holds a line address together with valid and dirty flags. It does not store data, and it does not model the next memory level.

On a miss, a 16-bit LFSR taken modulo the way count picks the victim way, and the new line is installed there at once as valid and clean. If the old occupant was valid and dirty, the block first presents a writeback request carrying that line's base address. It then presents a fill request for the line-aligned miss address. The request side stays stalled until the fill handshake completes. A store miss marks the filled way dirty at that point. Seven statistics counters record accesses, misses, bytes and writebacks.

The set count must be a power of two. The line size must be a power of two of at least 8 bytes. Any other configuration stops elaboration.

Top module: `wb_tag_ctrl`

## Requirements
- R1: After reset, every counter reads zero, `req_ready` is high, no response, writeback or fill is pending, and every way is invalid, so the first access to any line misses.
- R2: The line number is address >> log2(LINE_BYTES) and the set is the line number modulo SETS. A request hits when a valid way of its set holds the same full line number. The dirty flag is ignored for the comparison.
- R3: A read hit leaves the tag state unchanged, so the line stays clean. A store hit sets the matching way's dirty flag.
- R4: The LFSR is 16 bits wide, seeded 16'hACE1, and advances only on a miss. Each step shifts left and inserts bit15^bit13^bit12^bit10 as the new bit 0. The victim way is the pre-step state modulo WAYS.
- R5: A miss installs the new line in the victim way as valid and clean. A store miss sets that way dirty when the fill handshake completes.
- R6: A writeback is presented only when the victim was valid and dirty, and its address is the victim line number << log2(LINE_BYTES). `wb_valid` and `wb_addr` hold until `wb_ready`.
- R7: After any writeback, a fill is presented with address = line number << log2(LINE_BYTES). A fill and a writeback are never presented together.
- R8: `resp_valid` pulses for exactly one cycle, on the cycle after each accepted request. `req_ready` is low from the acceptance of a miss until the cycle after the fill handshake, and high otherwise.
- R9: Read access, write access, read miss and write miss counters each increment by one per matching event.
- R10: Each accepted request adds its byte count to the bytes-read or bytes-written counter.
- R11: The writeback counter increments once per writeback handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_addr | input | ADDR_W | Byte address of the access |
| req_bytes | input | BYTES_W | Byte count of the access |
| req_store | input | 1 | 1 = store, 0 = read |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_hit | output | 1 | Hit (1) or miss (0), valid with `resp_valid` |
| wb_valid | output | 1 | Writeback request to next level |
| wb_ready | input | 1 | Next level takes the writeback |
| wb_addr | output | ADDR_W | Line base address of the dirty victim |
| fill_valid | output | 1 | Line fill request to next level |
| fill_ready | input | 1 | Next level takes the fill |
| fill_addr | output | ADDR_W | Line base address to fetch |
| cnt_rd_acc | output | CNT_W | Read accesses |
| cnt_wr_acc | output | CNT_W | Store accesses |
| cnt_rd_miss | output | CNT_W | Read misses |
| cnt_wr_miss | output | CNT_W | Store misses |
| cnt_bytes_rd | output | CNT_W | Bytes read |
| cnt_bytes_wr | output | CNT_W | Bytes written |
| cnt_wb | output | CNT_W | Writebacks issued |

## Verification
The hit/miss result and the access, miss and byte counters all update at the accepting edge. The bench therefore samples them at the falling edge just after acceptance, one cycle after driving the request. A writeback or fill request appears in that same sample. After each handshake edge, the bench looks at the next falling edge for the following request, for the writeback counter, and for `req_ready` to return. The bench sometimes holds `wb_ready` and `fill_ready` low for several cycles before granting them, and checks that the stall and the request address persist through that delay.

// File: rtl/wbtc_pkg.sv
package wbtc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_FILL} wbtc_state_e;

  // Fibonacci step: shift left, feedback from taps 15,13,12,10
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/wbtc_lfsr.sv
module wbtc_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  output logic [15:0] state
);
  always_ff @(posedge clk) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= wbtc_pkg::lfsr_step(state);
  end
endmodule

// File: rtl/wbtc_tag_store.sv
module wbtc_tag_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int TAG_W = 12,
  parameter int IDX_W = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  input  logic [WAY_W-1:0] rd_way,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             install,
  input  logic [WAY_W-1:0] in_way,
  input  logic             mark_dirty,
  input  logic [IDX_W-1:0] md_idx,
  input  logic [WAY_W-1:0] md_way
);
  logic             vld_q [SETS][WAYS];
  logic             drt_q [SETS][WAYS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (match[w]) hit_way = WAY_W'(w);
  end
  assign hit      = |match;
  assign rd_valid = vld_q[lk_idx][rd_way];
  assign rd_dirty = drt_q[lk_idx][rd_way];
  assign rd_tag   = tag_q[lk_idx][rd_way];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w] <= 1'b0;
          drt_q[s][w] <= 1'b0;
          tag_q[s][w] <= '0;
        end
    end else begin
      if (install) begin
        vld_q[lk_idx][in_way] <= 1'b1;
        drt_q[lk_idx][in_way] <= 1'b0;
        tag_q[lk_idx][in_way] <= lk_tag;
      end
      if (mark_dirty) drt_q[md_idx][md_way] <= 1'b1;
    end
  end
endmodule

// File: rtl/wbtc_stats.sv
module wbtc_stats #(
  parameter int CNT_W   = 32,
  parameter int BYTES_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_evt,
  input  logic               acc_store,
  input  logic [BYTES_W-1:0] acc_bytes,
  input  logic               miss_evt,
  input  logic               wb_evt,
  output logic [CNT_W-1:0]   rd_acc,
  output logic [CNT_W-1:0]   wr_acc,
  output logic [CNT_W-1:0]   rd_miss,
  output logic [CNT_W-1:0]   wr_miss,
  output logic [CNT_W-1:0]   bytes_rd,
  output logic [CNT_W-1:0]   bytes_wr,
  output logic [CNT_W-1:0]   wbs
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_acc <= '0; wr_acc <= '0; rd_miss <= '0; wr_miss <= '0;
      bytes_rd <= '0; bytes_wr <= '0; wbs <= '0;
    end else begin
      if (acc_evt && !acc_store) begin
        rd_acc   <= rd_acc + 1'b1;
        bytes_rd <= bytes_rd + CNT_W'(acc_bytes);
        if (miss_evt) rd_miss <= rd_miss + 1'b1;
      end
      if (acc_evt && acc_store) begin
        wr_acc   <= wr_acc + 1'b1;
        bytes_wr <= bytes_wr + CNT_W'(acc_bytes);
        if (miss_evt) wr_miss <= wr_miss + 1'b1;
      end
      if (wb_evt) wbs <= wbs + 1'b1;
    end
  end
endmodule

// File: rtl/wb_tag_ctrl.sv
module wb_tag_ctrl #(
  parameter int          ADDR_W     = 32,
  parameter int          SETS       = 64,
  parameter int          WAYS       = 4,
  parameter int          LINE_BYTES = 64,
  parameter int          BYTES_W    = 8,
  parameter int          CNT_W      = 32,
  parameter logic [15:0] LFSR_SEED  = 16'hACE1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [BYTES_W-1:0] req_bytes,
  input  logic               req_store,
  output logic               resp_valid,
  output logic               resp_hit,
  output logic               wb_valid,
  input  logic               wb_ready,
  output logic [ADDR_W-1:0]  wb_addr,
  output logic               fill_valid,
  input  logic               fill_ready,
  output logic [ADDR_W-1:0]  fill_addr,
  output logic [CNT_W-1:0]   cnt_rd_acc,
  output logic [CNT_W-1:0]   cnt_wr_acc,
  output logic [CNT_W-1:0]   cnt_rd_miss,
  output logic [CNT_W-1:0]   cnt_wr_miss,
  output logic [CNT_W-1:0]   cnt_bytes_rd,
  output logic [CNT_W-1:0]   cnt_bytes_wr,
  output logic [CNT_W-1:0]   cnt_wb
);
  import wbtc_pkg::*;

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  if (SETS < 1 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
    $error("SETS must be a power of two");
  end
  if (LINE_BYTES < 8 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
    $error("LINE_BYTES must be a power of two of at least 8");
  end

  function automatic logic [TAG_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction
  function automatic logic [IDX_W-1:0] set_of(input logic [TAG_W-1:0] l);
    return IDX_W'(l % TAG_W'(SETS));
  endfunction
  function automatic logic [ADDR_W-1:0] base_of(input logic [TAG_W-1:0] l);
    return {l, {OFF_W{1'b0}}};
  endfunction

  wbtc_state_e      state_q;
  logic [TAG_W-1:0] cur_line_q, vic_line_q;
  logic [IDX_W-1:0] cur_idx_q;
  logic [WAY_W-1:0] cur_way_q;
  logic             cur_store_q;
  logic             resp_valid_q, resp_hit_q;

  logic [TAG_W-1:0] req_line;
  logic [IDX_W-1:0] req_set;
  logic             lk_hit, vic_valid, vic_dirty;
  logic [WAY_W-1:0] lk_way, victim;
  logic [TAG_W-1:0] vic_tag;
  logic [15:0]      lfsr_q;

  // named events for the checker
  logic evt_accept, evt_miss, evt_hit_store, evt_wb_fire, evt_fill_fire;

  assign req_line      = line_of(req_addr);
  assign req_set       = set_of(req_line);
  assign victim        = WAY_W'(lfsr_q % 16'(WAYS));
  assign req_ready     = (state_q == ST_IDLE);
  assign evt_accept    = req_valid && req_ready;
  assign evt_miss      = evt_accept && !lk_hit;
  assign evt_hit_store = evt_accept && lk_hit && req_store;
  assign evt_wb_fire   = wb_valid && wb_ready;
  assign evt_fill_fire = fill_valid && fill_ready;

  wbtc_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(evt_miss), .state(lfsr_q)
  );

  wbtc_tag_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(req_set), .lk_tag(req_line),
    .hit(lk_hit), .hit_way(lk_way),
    .rd_way(victim), .rd_valid(vic_valid), .rd_dirty(vic_dirty), .rd_tag(vic_tag),
    .install(evt_miss), .in_way(victim),
    .mark_dirty(evt_hit_store || (evt_fill_fire && cur_store_q)),
    .md_idx(evt_fill_fire ? cur_idx_q : req_set),
    .md_way(evt_fill_fire ? cur_way_q : lk_way)
  );

  wbtc_stats #(.CNT_W(CNT_W), .BYTES_W(BYTES_W)) u_stats (
    .clk(clk), .rst_n(rst_n),
    .acc_evt(evt_accept), .acc_store(req_store), .acc_bytes(req_bytes),
    .miss_evt(evt_miss), .wb_evt(evt_wb_fire),
    .rd_acc(cnt_rd_acc), .wr_acc(cnt_wr_acc),
    .rd_miss(cnt_rd_miss), .wr_miss(cnt_wr_miss),
    .bytes_rd(cnt_bytes_rd), .bytes_wr(cnt_bytes_wr), .wbs(cnt_wb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cur_line_q   <= '0;
      vic_line_q   <= '0;
      cur_idx_q    <= '0;
      cur_way_q    <= '0;
      cur_store_q  <= 1'b0;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
    end else begin
      resp_valid_q <= evt_accept;
      resp_hit_q   <= evt_accept && lk_hit;
      unique case (state_q)
        ST_IDLE: if (evt_miss) begin
          cur_line_q  <= req_line;
          cur_idx_q   <= req_set;
          cur_way_q   <= victim;
          cur_store_q <= req_store;
          vic_line_q  <= vic_tag;
          state_q     <= (vic_valid && vic_dirty) ? ST_WB : ST_FILL;
        end
        ST_WB:   if (wb_ready)   state_q <= ST_FILL;
        ST_FILL: if (fill_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign resp_valid = resp_valid_q;
  assign resp_hit   = resp_hit_q;
  assign wb_valid   = (state_q == ST_WB);
  assign wb_addr    = base_of(vic_line_q);
  assign fill_valid = (state_q == ST_FILL);
  assign fill_addr  = base_of(cur_line_q);
endmodule

// File: rtl/wbtc_chk.sv
module wbtc_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              req_store,
  input logic              resp_valid,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [ADDR_W-1:0] wb_addr,
  input logic              fill_valid,
  input logic [ADDR_W-1:0] fill_addr,
  input logic              evt_accept,
  input logic              evt_miss,
  input logic [CNT_W-1:0]  cnt_rd_acc,
  input logic [CNT_W-1:0]  cnt_wb
);
  assert_stall_refill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid || fill_valid) |-> !req_ready);
  assert_resp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> resp_valid);
  assert_resp_only_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(evt_accept));
  assert_wb_after_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> $past(evt_miss));
  assert_wb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));
  assert_fill_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (fill_addr[OFF_W-1:0] == '0));
  assert_fill_not_with_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !fill_valid);
  assert_read_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_accept && !req_store) |=> (cnt_rd_acc == $past(cnt_rd_acc) + 1'b1));
  assert_wb_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready) |=> (cnt_wb == $past(cnt_wb) + 1'b1));
endmodule

bind wb_tag_ctrl wbtc_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_store(req_store),
  .resp_valid(resp_valid), .wb_valid(wb_valid), .wb_ready(wb_ready),
  .wb_addr(wb_addr), .fill_valid(fill_valid), .fill_addr(fill_addr),
  .evt_accept(evt_accept), .evt_miss(evt_miss),
  .cnt_rd_acc(cnt_rd_acc), .cnt_wb(cnt_wb)
);

// File: tb/sim_wb_tag_ctrl.sv
`timescale 1ns/1ps
module sim_wb_tag_ctrl;
  localparam int AW = 16, NS = 4, NW = 2, LB = 16, BW = 8, CW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_store = 0, wb_ready = 0, fill_ready = 0;
  logic [AW-1:0] req_addr = '0;
  logic [BW-1:0] req_bytes = '0;
  logic req_ready, resp_valid, resp_hit, wb_valid, fill_valid;
  logic [AW-1:0] wb_addr, fill_addr;
  logic [CW-1:0] c_ra, c_wa, c_rm, c_wm, c_br, c_bw, c_wb;

  always #10 clk = ~clk;

  wb_tag_ctrl #(.ADDR_W(AW), .SETS(NS), .WAYS(NW), .LINE_BYTES(LB),
                .BYTES_W(BW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_store(req_store),
    .resp_valid(resp_valid), .resp_hit(resp_hit),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr),
    .cnt_rd_acc(c_ra), .cnt_wr_acc(c_wa), .cnt_rd_miss(c_rm), .cnt_wr_miss(c_wm),
    .cnt_bytes_rd(c_br), .cnt_bytes_wr(c_bw), .cnt_wb(c_wb)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  bit m_v [NS][NW];
  bit m_d [NS][NW];
  int m_t [NS][NW];
  int rng = 16'hACE1;
  int e_ra = 0, e_wa = 0, e_rm = 0, e_wm = 0, e_br = 0, e_bw = 0, e_wb = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_counters();
    chk(c_ra == e_ra, "R9", "read accesses", c_ra, e_ra);
    chk(c_wa == e_wa, "R9", "write accesses", c_wa, e_wa);
    chk(c_rm == e_rm, "R9", "read misses", c_rm, e_rm);
    chk(c_wm == e_wm, "R9", "write misses", c_wm, e_wm);
    chk(c_br == e_br, "R10", "bytes read", c_br, e_br);
    chk(c_bw == e_bw, "R10", "bytes written", c_bw, e_bw);
    chk(c_wb == e_wb, "R11", "writebacks", c_wb, e_wb);
  endtask

  task automatic access(input int addr, input int nbytes, input bit st, input int dly);
    int line = addr / LB;
    int set  = line % NS;
    int hw   = -1;
    int vw, ot;
    bit ov, od;
    for (int w = 0; w < NW; w++) if (m_v[set][w] && m_t[set][w] == line) hw = w;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8", "ready when idle", req_ready, 1);
    req_valid = 1; req_addr = AW'(addr); req_bytes = BW'(nbytes); req_store = st;
    @(negedge clk);
    req_valid = 0;
    chk(resp_valid == 1'b1, "R8", "response strobe", resp_valid, 1);
    chk(resp_hit == (hw >= 0), "R2", "hit flag", resp_hit, hw >= 0);
    if (st) begin e_wa++; e_bw += nbytes; end else begin e_ra++; e_br += nbytes; end
    if (hw >= 0) begin
      if (st) m_d[set][hw] = 1;                       // R3
      chk(req_ready == 1'b1, "R8", "no stall on hit", req_ready, 1);
    end else begin
      if (st) e_wm++; else e_rm++;
      vw = rng % NW;                                  // R4
      rng = ((rng << 1) & 16'hFFFF) | (((rng >> 15) ^ (rng >> 13) ^ (rng >> 12) ^ (rng >> 10)) & 1);
      ov = m_v[set][vw]; od = m_d[set][vw]; ot = m_t[set][vw];
      m_v[set][vw] = 1; m_d[set][vw] = 0; m_t[set][vw] = line;   // R5
      chk(req_ready == 1'b0, "R8", "stall on miss", req_ready, 0);
      if (ov && od) begin
        chk(wb_valid == 1'b1, "R6", "writeback issued", wb_valid, 1);
        chk(wb_addr == AW'(ot * LB), "R6", "writeback address", wb_addr, ot * LB);
        chk(fill_valid == 1'b0, "R7", "fill waits for writeback", fill_valid, 0);
        repeat (dly) @(negedge clk);
        chk(wb_valid && wb_addr == AW'(ot * LB), "R6", "writeback held", wb_addr, ot * LB);
        chk(req_ready == 1'b0, "R8", "stall while writeback waits", req_ready, 0);
        wb_ready = 1;
        @(negedge clk);
        wb_ready = 0;
        e_wb++;
        chk(c_wb == e_wb, "R11", "writeback count", c_wb, e_wb);
      end else begin
        chk(wb_valid == 1'b0, "R6", "no writeback for clean/invalid victim", wb_valid, 0);
      end
      chk(fill_valid == 1'b1, "R7", "fill issued", fill_valid, 1);
      chk(fill_addr == AW'(line * LB), "R7", "fill address", fill_addr, line * LB);
      repeat (dly) @(negedge clk);
      chk(req_ready == 1'b0, "R8", "stall while fill waits", req_ready, 0);
      fill_ready = 1;
      @(negedge clk);
      fill_ready = 0;
      chk(req_ready == 1'b1, "R8", "ready after fill", req_ready, 1);
      chk(fill_valid == 1'b0, "R7", "fill dropped", fill_valid, 0);
      if (st) m_d[set][vw] = 1;                       // R5 store miss dirty
    end
    chk_counters();
  endtask

  initial begin
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin m_v[s][w] = 0; m_d[s][w] = 0; m_t[s][w] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(!resp_valid && !wb_valid && !fill_valid, "R1", "nothing pending",
        {resp_valid, wb_valid, fill_valid}, 0);
    chk_counters();
    // R1/R2: first touch misses; R3: read hit keeps line clean
    access(16'h0040, 4, 0, 0);
    access(16'h0048, 4, 0, 0);
    // R3: store hit dirties; R5/R6 later eviction writes back
    access(16'h0044, 2, 1, 1);
    // R2: same set, different line, full line number compared
    access(16'h0080 + 16'h0040, 8, 0, 2);
    // sweep: 24 lines over 4 sets, mixed reads and stores, varying delays
    for (int i = 0; i < 400; i++) begin
      int ln = (i * 7 + (i / 5) * 3) % 24;
      access(ln * LB + (i % LB), 1 + (i % 8), (i % 3) == 1, i % 3);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule